// File: doc/BRIEF.md
# Dual-Source Cell Scanout Engine

This block turns a character screen or a packed bitmap into a serial monochrome pixel stream, one pixel per clock, with an active-area flag beside it. The screen is a grid of 8-pixel-wide cells: `COLS` columns by `ROWS` rows, each row `CELL_H` scanlines tall. By default this is 80 by 24 cells of 8x12 pixels, which gives 640x288 pixels. Each scanline is followed by a horizontal gap of whole cell times. Each frame ends with a vertical gap of whole cell rows. Sync pulse shaping is left to a neighbouring block. That block can derive its timing from the active flag and the fixed line and frame periods.

Two sources feed the stream, and a mode input chooses between them. In text mode, a character code is read from the text buffer. The code is then expanded through a glyph ROM that holds 16 bytes per glyph. A rectangular cursor and a per-character reverse bit can each invert the cell. In bitmap mode, the bytes come straight from a linear buffer with `LINE_BYTES` bytes per scanline. Any address beyond the end of that buffer reads as dark. Both modes honour a hardware row scroll.

All three memories sit outside the block behind plain synchronous read ports with one clock of latency. The block drives the address for the next cell during the whole of the current cell, so the stream never stalls. The mode and scroll inputs are captured once per frame, in the last blanking line, so a frame is never torn.

Top module: `cellmap_scanout`

## Requirements
- R1: While `rst_n` is low, `active` and `pix` are 0. After release, the first active pixel appears after the 8th rising edge. The first frame after reset is always text mode with scroll 0.
- R2: Each scanline lasts `(COLS+H_BLANK_CELLS)*8` clocks, and `active` is high for its first `COLS*8` clocks. A frame has `(ROWS+V_BLANK_ROWS)*CELL_H` scanlines, and only the first `ROWS*CELL_H` of them are active.
- R3: In text mode, the code for cell (column c, fetched row s) is read at `txt_addr = s*COLS + c`. Scanline `l` of the cell shows the ROM byte at `rom_addr = {code[6:0], l[3:0]}`, and bit 0 of that byte is the leftmost pixel.
- R4: In text mode, a code with bit 7 set inverts all 8 pixels of its cell.
- R5: In text mode with `cur_en` high, a cell is inverted when its column lies in [`cur_col_lo`, `cur_col_hi`] and its on-screen row lies in [`cur_row_lo`, `cur_row_hi`], both inclusive. When a cell is both cursored and reverse, the two inversions cancel.
- R6: For on-screen row y, the fetched row is `(scroll_row + y) mod ROWS`. `scroll_row` must be below `ROWS`. `txt_addr` stays below `ROWS*COLS`.
- R7: In bitmap mode, the byte for on-screen row y, scanline l and column c sits at full address `(s*CELL_H + l)*LINE_BYTES + c`, where s is the fetched row. `bmp_addr` carries the low `BMP_AW` bits of that address, and bit 0 is the leftmost pixel.
- R8: In bitmap mode, a full address of `2**BMP_AW` or more gives an all-dark byte. The cursor and code bit 7 have no effect in bitmap mode.
- R9: A change on `mode_bmp` or `scroll_row` takes effect only at the next frame start. Those inputs are captured during the last blanking scanline, so a frame already in progress is unaffected.
- R10: `pix` is 0 whenever `active` is 0.
- R11: The addresses for a cell are driven for all 8 clocks of the preceding cell and held steady after its first clock. Read data is expected one clock after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_bmp | input | 1 | 0 = text source, 1 = bitmap source (captured per frame) |
| scroll_row | input | RW | Row scroll offset, below ROWS (captured per frame) |
| cur_en | input | 1 | Cursor enable |
| cur_col_lo | input | CXW | First cursor column |
| cur_col_hi | input | CXW | Last cursor column |
| cur_row_lo | input | RW | First cursor on-screen row |
| cur_row_hi | input | RW | Last cursor on-screen row |
| txt_addr | output | TAW | Text buffer read address |
| txt_data | input | 8 | Text buffer read data, one clock after address |
| rom_addr | output | 11 | Glyph ROM read address |
| rom_data | input | 8 | Glyph ROM read data, one clock after address |
| bmp_addr | output | BMP_AW | Bitmap buffer read address |
| bmp_data | input | 8 | Bitmap buffer read data, one clock after address |
| pix | output | 1 | Pixel value |
| active | output | 1 | Pixel lies in the visible area |

## Verification
The bench builds the block with 4 columns, 3 rows of 3-scanline cells, 2 blank cells per line, one blank row, 8 bytes per bitmap line and a 64-byte bitmap. That gives a 576-clock frame, so seven complete frames run in a few thousand cycles. With these values the scroll wrap is reached at every offset. In bitmap mode the last scanline of the last fetched row falls beyond the buffer, which exercises the dark fill. Mode and scroll are switched in the middle of active frames to show that the captured values are held. Frames mix text and bitmap with cursor rectangles at the screen edges and reverse codes inside and outside the cursor.

// File: rtl/cellmap_scanout_pkg.sv
// Shared constants and types of the cell scanout engine.
// Assumes 8-pixel cells and glyphs stored on a 16-byte stride.
package cellmap_scanout_pkg;
    localparam int CELL_W     = 8;
    localparam int GLYPH_LG   = 4;
    localparam int ROM_AW     = 7 + GLYPH_LG;

    typedef enum logic {
        SRC_TEXT   = 1'b0,
        SRC_BITMAP = 1'b1
    } src_e;
endpackage

// File: rtl/cellmap_scan_raster.sv
// Raster position counters and next-cell target.
// The counters track the cell being shown. The target names the cell
// whose byte is being fetched now (the next one in scan order).
// Assumes HC_TOTAL >= COLS+2 and CELL_H >= 2.
module cellmap_scan_raster #(
    parameter int COLS     = 80,
    parameter int ROWS     = 24,
    parameter int CELL_H   = 12,
    parameter int HC_TOTAL = 100,
    parameter int RTOT     = 26,
    parameter int CXW      = 7,
    parameter int SLW      = 4,
    parameter int RW       = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [2:0]     px,
    output logic           cell_end,
    output logic           active,
    output logic           latch_pt,
    output logic [CXW-1:0] tcol,
    output logic [SLW-1:0] tsl,
    output logic [RW-1:0]  trr
);
    logic [CXW-1:0] cx;
    logic [SLW-1:0] sl;
    logic [RW-1:0]  rr;
    logic           last_sl;
    logic           last_rr;

    assign cell_end = (px == 3'd7);
    assign last_sl  = (sl == SLW'(CELL_H - 1));
    assign last_rr  = (rr == RW'(RTOT - 1));
    assign active   = (cx < CXW'(COLS)) && (rr < RW'(ROWS));
    assign latch_pt = last_rr && last_sl && (cx == CXW'(HC_TOTAL - 2)) && cell_end;

    // Advance pixel, cell, scanline and row counters; reset parks on the prefetch cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px <= 3'd0;
            cx <= CXW'(HC_TOTAL - 1);
            sl <= SLW'(CELL_H - 1);
            rr <= RW'(RTOT - 1);
        end else begin
            px <= px + 3'd1;
            if (cell_end) begin
                if (cx == CXW'(HC_TOTAL - 1)) begin
                    cx <= '0;
                    if (last_sl) begin
                        sl <= '0;
                        rr <= last_rr ? '0 : rr + RW'(1);
                    end else begin
                        sl <= sl + SLW'(1);
                    end
                end else begin
                    cx <= cx + CXW'(1);
                end
            end
        end
    end

    // Pick the cell fetched during the current one: right neighbour or next line start.
    always_comb begin
        if (cx < CXW'(COLS - 1)) begin
            tcol = cx + CXW'(1);
            tsl  = sl;
            trr  = rr;
        end else begin
            tcol = '0;
            if (last_sl) begin
                tsl = '0;
                trr = last_rr ? '0 : rr + RW'(1);
            end else begin
                tsl = sl + SLW'(1);
                trr = rr;
            end
        end
    end
endmodule

// File: rtl/cellmap_scan_fetch.sv
// Address generation for the target cell: scrolled row, text and bitmap
// addresses, end-of-buffer flag, cursor hit and glyph ROM address.
// Assumes scroll < ROWS; rows in vertical blank fetch row 0.
module cellmap_scan_fetch
    import cellmap_scanout_pkg::*;
#(
    parameter int COLS       = 80,
    parameter int ROWS       = 24,
    parameter int CELL_H     = 12,
    parameter int LINE_BYTES = 128,
    parameter int BMP_AW     = 15,
    parameter int CXW        = 7,
    parameter int SLW        = 4,
    parameter int RW         = 5,
    parameter int TAW        = 11
) (
    input  logic [CXW-1:0]    tcol,
    input  logic [SLW-1:0]    tsl,
    input  logic [RW-1:0]     trr,
    input  logic [RW-1:0]     scroll,
    input  logic              cur_en,
    input  logic [CXW-1:0]    cur_col_lo,
    input  logic [CXW-1:0]    cur_col_hi,
    input  logic [RW-1:0]     cur_row_lo,
    input  logic [RW-1:0]     cur_row_hi,
    input  logic [6:0]        code_lo,
    output logic [TAW-1:0]    txt_addr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [BMP_AW-1:0] bmp_addr,
    output logic              bmp_oob,
    output logic              cur_hit
);
    localparam int BMP_BYTES = 1 << BMP_AW;

    logic [RW:0]   sum;
    logic [RW-1:0] srow;
    int unsigned   tlin;
    int unsigned   bfull;

    // Fold the scroll offset into the visible row range with one subtract.
    always_comb begin
        sum = {1'b0, scroll} + {1'b0, trr};
        if (trr < RW'(ROWS))
            srow = (sum >= (RW+1)'(ROWS)) ? RW'(sum - (RW+1)'(ROWS)) : RW'(sum);
        else
            srow = '0;
    end

    // Linear addresses for both sources and the end-of-bitmap flag.
    always_comb begin
        tlin     = int'(srow) * COLS + int'(tcol);
        bfull    = (int'(srow) * CELL_H + int'(tsl)) * LINE_BYTES + int'(tcol);
        txt_addr = TAW'(tlin);
        bmp_addr = BMP_AW'(bfull);
        bmp_oob  = (bfull >= BMP_BYTES);
    end

    assign rom_addr = {code_lo, GLYPH_LG'(tsl)};
    assign cur_hit  = cur_en && (tcol >= cur_col_lo) && (tcol <= cur_col_hi)
                      && (trr >= cur_row_lo) && (trr <= cur_row_hi);
endmodule

// File: rtl/cellmap_scan_shift.sv
// Forms the next cell byte from the selected source and shifts it out
// least-significant bit first, gated by the active flag.
// Assumes source data is valid at the last clock of the preceding cell.
module cellmap_scan_shift
    import cellmap_scanout_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  src_e       src,
    input  logic       load,
    input  logic       active,
    input  logic [7:0] rom_data,
    input  logic       code_rev,
    input  logic       cur_hit,
    input  logic [7:0] bmp_data,
    input  logic       bmp_oob,
    output logic       pix
);
    logic [7:0] nbyte;
    logic [7:0] shreg;

    // Choose bitmap byte or glyph byte with cursor and reverse inversions.
    always_comb begin
        if (src == SRC_BITMAP)
            nbyte = bmp_oob ? 8'h00 : bmp_data;
        else
            nbyte = rom_data ^ {8{cur_hit}} ^ {8{code_rev}};
    end

    // Load at cell boundary, otherwise shift toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= 8'h00;
        else if (load)
            shreg <= nbyte;
        else
            shreg <= shreg >> 1;
    end

    assign pix = active & shreg[0];
endmodule

// File: rtl/cellmap_scanout.sv
// Top of the dual-source cell scanout engine: raster counters, address
// generation and pixel shifter, plus per-frame capture of mode and scroll.
// Assumes external memories with one clock of read latency.
module cellmap_scanout
    import cellmap_scanout_pkg::*;
#(
    parameter int COLS          = 80,
    parameter int ROWS          = 24,
    parameter int CELL_H        = 12,
    parameter int H_BLANK_CELLS = 20,
    parameter int V_BLANK_ROWS  = 2,
    parameter int LINE_BYTES    = 128,
    parameter int BMP_AW        = 15,
    localparam int HC_TOTAL     = COLS + H_BLANK_CELLS,
    localparam int RTOT         = ROWS + V_BLANK_ROWS,
    localparam int CXW          = $clog2(HC_TOTAL),
    localparam int RW           = $clog2(RTOT),
    localparam int SLW          = (CELL_H > 1) ? $clog2(CELL_H) : 1,
    localparam int TAW          = $clog2(ROWS * COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_bmp,
    input  logic [RW-1:0]     scroll_row,
    input  logic              cur_en,
    input  logic [CXW-1:0]    cur_col_lo,
    input  logic [CXW-1:0]    cur_col_hi,
    input  logic [RW-1:0]     cur_row_lo,
    input  logic [RW-1:0]     cur_row_hi,
    output logic [TAW-1:0]    txt_addr,
    input  logic [7:0]        txt_data,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [7:0]        rom_data,
    output logic [BMP_AW-1:0] bmp_addr,
    input  logic [7:0]        bmp_data,
    output logic              pix,
    output logic              active
);
    src_e           mode_q;
    logic [RW-1:0]  scroll_q;
    logic [2:0]     ras_px;
    logic           cell_end;
    logic           latch_pt;
    logic [CXW-1:0] tcol;
    logic [SLW-1:0] tsl;
    logic [RW-1:0]  trr;
    logic           bmp_oob;
    logic           cur_hit;

    // Capture source and scroll once per frame, in the last blank scanline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= SRC_TEXT;
            scroll_q <= '0;
        end else if (latch_pt) begin
            mode_q   <= src_e'(mode_bmp);
            scroll_q <= scroll_row;
        end
    end

    cellmap_scan_raster #(
        .COLS(COLS), .ROWS(ROWS), .CELL_H(CELL_H), .HC_TOTAL(HC_TOTAL),
        .RTOT(RTOT), .CXW(CXW), .SLW(SLW), .RW(RW)
    ) u_ras (
        .clk(clk), .rst_n(rst_n), .px(ras_px), .cell_end(cell_end),
        .active(active), .latch_pt(latch_pt),
        .tcol(tcol), .tsl(tsl), .trr(trr)
    );

    cellmap_scan_fetch #(
        .COLS(COLS), .ROWS(ROWS), .CELL_H(CELL_H), .LINE_BYTES(LINE_BYTES),
        .BMP_AW(BMP_AW), .CXW(CXW), .SLW(SLW), .RW(RW), .TAW(TAW)
    ) u_fetch (
        .tcol(tcol), .tsl(tsl), .trr(trr), .scroll(scroll_q),
        .cur_en(cur_en), .cur_col_lo(cur_col_lo), .cur_col_hi(cur_col_hi),
        .cur_row_lo(cur_row_lo), .cur_row_hi(cur_row_hi),
        .code_lo(txt_data[6:0]),
        .txt_addr(txt_addr), .rom_addr(rom_addr), .bmp_addr(bmp_addr),
        .bmp_oob(bmp_oob), .cur_hit(cur_hit)
    );

    cellmap_scan_shift u_shift (
        .clk(clk), .rst_n(rst_n), .src(mode_q), .load(cell_end),
        .active(active), .rom_data(rom_data), .code_rev(txt_data[7]),
        .cur_hit(cur_hit), .bmp_data(bmp_data), .bmp_oob(bmp_oob),
        .pix(pix)
    );
endmodule

// File: rtl/cellmap_scanout_chk.sv
// Property checker for the cell scanout engine, bound onto the top module.
// Assumes the scroll input is kept below the row count.
module cellmap_scanout_chk #(
    parameter int TAW       = 11,
    parameter int BAW       = 15,
    parameter int TXT_CELLS = 1920
) (
    input logic           clk,
    input logic           rst_n,
    input logic           active,
    input logic           pix,
    input logic [TAW-1:0] txt_addr,
    input logic [BAW-1:0] bmp_addr,
    input logic [2:0]     px,
    input logic           mode_q
);
    // Outside the visible area the pixel stays dark.
    p_dark_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !pix);

    // Fetch addresses hold still after the first clock of each cell.
    p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (px != 3'd0) |-> ($stable(txt_addr) && $stable(bmp_addr)));

    // Scrolled text address never leaves the text buffer.
    p_txt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(txt_addr) < TXT_CELLS);

    // The captured source only switches while the screen is blank.
    p_mode_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> !active);

    // A visible run lasts longer than one pixel.
    p_active_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |=> active);
endmodule

bind cellmap_scanout cellmap_scanout_chk #(
    .TAW(TAW), .BAW(BMP_AW), .TXT_CELLS(ROWS * COLS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .active(active), .pix(pix),
    .txt_addr(txt_addr), .bmp_addr(bmp_addr), .px(ras_px),
    .mode_q(mode_q)
);

// File: tb/sim_cellmap_scanout.sv
// Bench for the cell scanout engine: behavioural memories, per-frame
// configurations and a per-clock reference model of every pixel.
module sim_cellmap_scanout;
    localparam int COLS = 4;
    localparam int ROWS = 3;
    localparam int CH   = 3;
    localparam int HB   = 2;
    localparam int VB   = 1;
    localparam int LB   = 8;
    localparam int BAW  = 6;
    localparam int BSZ  = 1 << BAW;
    localparam int LC   = (COLS + HB) * 8;
    localparam int ALN  = ROWS * CH;
    localparam int FR   = LC * (ROWS + VB) * CH;
    localparam int NFR  = 7;
    localparam int TAW  = $clog2(ROWS * COLS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_bmp;
    logic [1:0] scroll_row;
    logic cur_en;
    logic [2:0] cur_col_lo, cur_col_hi;
    logic [1:0] cur_row_lo, cur_row_hi;
    logic [TAW-1:0] txt_addr;
    logic [10:0] rom_addr;
    logic [BAW-1:0] bmp_addr;
    logic [7:0] txt_data, rom_data, bmp_data;
    logic pix, active;

    logic [7:0] txt_mem [COLS*ROWS];
    logic [7:0] rom_mem [2048];
    logic [7:0] bmp_mem [BSZ];

    int c_mode [NFR+1];
    int c_scr  [NFR+1];
    int c_cen  [NFR+1];
    int c_cl   [NFR+1];
    int c_ch   [NFR+1];
    int c_rl   [NFR+1];
    int c_rh   [NFR+1];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    cellmap_scanout #(
        .COLS(COLS), .ROWS(ROWS), .CELL_H(CH), .H_BLANK_CELLS(HB),
        .V_BLANK_ROWS(VB), .LINE_BYTES(LB), .BMP_AW(BAW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .mode_bmp(mode_bmp), .scroll_row(scroll_row),
        .cur_en(cur_en), .cur_col_lo(cur_col_lo), .cur_col_hi(cur_col_hi),
        .cur_row_lo(cur_row_lo), .cur_row_hi(cur_row_hi),
        .txt_addr(txt_addr), .txt_data(txt_data),
        .rom_addr(rom_addr), .rom_data(rom_data),
        .bmp_addr(bmp_addr), .bmp_data(bmp_data),
        .pix(pix), .active(active)
    );

    // Synchronous read ports with one clock of latency.
    always @(posedge clk) begin
        txt_data <= txt_mem[txt_addr];
        rom_data <= rom_mem[rom_addr];
        bmp_data <= bmp_mem[bmp_addr];
    end

    task automatic set_cfg(input int m, input int s, input int e,
                           input int cl, input int chh, input int rl, input int rh, input int f);
        c_mode[f] = m; c_scr[f] = s; c_cen[f] = e;
        c_cl[f] = cl; c_ch[f] = chh; c_rl[f] = rl; c_rh[f] = rh;
    endtask

    task automatic drive_src(input int f);
        mode_bmp   = (c_mode[f] != 0);
        scroll_row = 2'(c_scr[f]);
    endtask

    task automatic drive_cur(input int f);
        cur_en     = (c_cen[f] != 0);
        cur_col_lo = 3'(c_cl[f]);
        cur_col_hi = 3'(c_ch[f]);
        cur_row_lo = 2'(c_rl[f]);
        cur_row_hi = 2'(c_rh[f]);
    endtask

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic int srow_of(input int f, input int row);
        return (c_scr[f] + row) % ROWS;
    endfunction

    function automatic int cell_byte(input int f, input int row, input int sl, input int col);
        int sr, g, code, a;
        sr = srow_of(f, row);
        if (c_mode[f] == 0) begin
            code = int'(txt_mem[sr * COLS + col]);
            g = int'(rom_mem[(code & 127) * 16 + sl]);
            if (c_cen[f] != 0 && col >= c_cl[f] && col <= c_ch[f] && row >= c_rl[f] && row <= c_rh[f])
                g = g ^ 255;
            if ((code & 128) != 0) g = g ^ 255;
        end else begin
            a = (sr * CH + sl) * LB + col;
            g = (a < BSZ) ? int'(bmp_mem[a]) : 0;
        end
        return g;
    endfunction

    function automatic string tag_of(input int f, input int line, input int col);
        int row, sl, sr, code, a;
        bit cur;
        row = line / CH; sl = line % CH; sr = srow_of(f, row);
        if (f == 0) return "R1";
        if (line >= ALN / 2 && c_mode[f] != c_mode[f+1]) return "R9";
        if (c_mode[f] != 0) begin
            a = (sr * CH + sl) * LB + col;
            return (a >= BSZ || c_cen[f] != 0) ? "R8" : (c_scr[f] != 0 ? "R6" : "R7");
        end
        code = int'(txt_mem[sr * COLS + col]);
        cur = (c_cen[f] != 0 && col >= c_cl[f] && col <= c_ch[f] && row >= c_rl[f] && row <= c_rh[f]);
        if (cur) return "R5";
        if ((code & 128) != 0) return "R4";
        if (c_scr[f] != 0) return "R6";
        return "R3";
    endfunction

    // Watchdog: a hung run is one failed check, then the summary.
    initial begin
        #(4 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R2 watchdog: got no end of run expected end of run");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < COLS*ROWS; i++) txt_mem[i] = 8'((i * 37 + 5) ^ ((i & 1) << 7));
        for (int i = 0; i < 2048; i++)      rom_mem[i] = 8'((i * 13) + (i >> 3) + 1);
        for (int i = 0; i < BSZ; i++)       bmp_mem[i] = 8'(i * 29 + 7);

        // mode(0=text,1=bitmap), scroll, cursor enable, cols lo..hi, rows lo..hi
        set_cfg(0, 0, 1, 1, 2, 0, 1, 0);
        set_cfg(1, 0, 1, 0, 3, 0, 2, 1);
        set_cfg(0, 2, 0, 0, 0, 0, 0, 2);
        set_cfg(0, 1, 1, 3, 3, 2, 2, 3);
        set_cfg(1, 1, 0, 0, 0, 0, 0, 4);
        set_cfg(1, 2, 1, 0, 3, 0, 2, 5);
        set_cfg(0, 0, 1, 0, 0, 1, 2, 6);
        set_cfg(0, 0, 0, 0, 0, 0, 0, 7);

        drive_src(1);
        drive_cur(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "active in reset", int'(active), 0);
        check("R1", "pix in reset", int'(pix), 0);
        rst_n = 1'b1;

        for (int t = 1; t <= 8 + NFR * FR; t++) begin
            int p, f, r, line, hx, col, eact, epix;
            @(posedge clk);
            @(negedge clk);
            p = t - 8;
            if (p < 0) begin
                check("R1", "active before first frame", int'(active), 0);
                continue;
            end
            f = p / FR; r = p % FR; line = r / LC; hx = r % LC; col = hx / 8;
            eact = (line < ALN && hx < COLS * 8) ? 1 : 0;
            check("R2", "active", int'(active), eact);
            if (eact != 0) begin
                epix = (cell_byte(f, line / CH, line % CH, col) >> (hx % 8)) & 1;
                check(tag_of(f, line, col), "pix", int'(pix), epix);
                if ((hx % 8) == 3 && col < COLS - 1) begin
                    // R11: next cell address already on the port
                    if (c_mode[f] == 0)
                        check("R11", "txt_addr", int'(txt_addr),
                              srow_of(f, line / CH) * COLS + col + 1);
                    else
                        check("R11", "bmp_addr", int'(bmp_addr),
                              ((srow_of(f, line / CH) * CH + line % CH) * LB + col + 1) % BSZ);
                end
            end else begin
                check("R10", "pix while blank", int'(pix), 0);
            end
            // R9: source and scroll for the next frame switch mid-frame
            if (r == (ALN / 2) * LC) drive_src(f + 1);
            if (r == ALN * LC) drive_cur(f + 1);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule